// File: doc/BRIEF.md
# PHY Control-Register Sequencer

This block turns single register requests into the bus traffic needed to reach a control register inside a multi-lane serial transceiver. The transceiver is seen through a small memory-mapped window that exposes only one page of its register space at a time. Every access the sequencer makes is therefore two bus transfers. The first writes a page-select word into a fixed slot of the window, and the second touches the word inside the selected page.

A client request carries a 16-bit register address, a 5-bit device number, write data and a direction. The sequencer does not reach that register directly. It works through the transceiver's indirect command interface, which has a command/status register, an address register and a data register. It first polls the status bit until the transceiver is idle. It then loads the address register, and for a write also the data register, and starts the command. A read waits for idle a second time and then fetches the data register. A write responds as soon as the command is started.

Polls are spaced by a programmable number of clock cycles. A poll phase that keeps seeing busy is cut short by a poll-count limit, and the request then ends with an error response. Only one request is in flight at a time.

Top module: `phy_cr_engine`

## Requirements
- R1: Every word access is immediately preceded by a page-select write to window byte offset 0x800. The 12-bit page word has the device number in bits 11:7 and bits 15:9 of the register address in bits 6:0, zero-extended to the bus width.
- R2: The word access uses window byte offset {register address bits 8:0, 2'b00}. The indirect registers live at register addresses 0x80A0 (command/status), 0x80A1 (address) and 0x80A2 (data).
- R3: Once bus_stb is raised, bus_stb, bus_we, bus_addr and bus_wdata stay unchanged until bus_ack. Only one bus transfer is outstanding at a time.
- R4: A read request polls command/status until bit 0 (busy) reads 0. It then writes the target address to 0x80A1, writes 0x0001 (bit 0 start, bit 1 clear for read) to 0x80A0, polls again until idle, reads 0x80A2 and returns that value in rsp_rdata.
- R5: A write request polls until idle, writes the target address to 0x80A1, writes the data to 0x80A2 and writes 0x0003 (start plus write flag in bit 1) to 0x80A0. It then responds with no further bus transfer.
- R6: After a poll that reads busy, no bus transfer starts for at least POLL_GAP clock cycles.
- R7: If MAX_POLLS consecutive polls in one poll phase read busy, the request ends with rsp_err=1 and rsp_rdata=0, and no further bus transfer is made for it.
- R8: req_ready is high only while idle. It drops in the cycle after a request is taken. rsp_valid is a single-cycle pulse, and req_ready is high again in the following cycle.
- R9: The device number is sampled per request, so successive requests can address different devices through the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken when both high |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_dev | input | 5 | Device number placed in the page word |
| req_addr | input | 16 | Target transceiver register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Poll limit reached |
| rsp_rdata | output | DATA_W | Read result, 0 on error or write |
| bus_stb | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | 12 | Window byte offset |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer complete, at most one per bus_stb |

## Verification
The assertions assume that the window slave raises bus_ack only while bus_stb is high, acks each transfer exactly once, and presents read data in the acknowledge cycle. They also assume that a request's fields hold steady while req_valid waits. The bench's behavioural transceiver acks one cycle after each new strobe and drops the ack in the next cycle. The bench drives requests only when req_ready is high and releases req_valid right after acceptance. Busy behaviour is scripted per request: a chosen number of busy readings before the command, a chosen number after it, or busy forever to reach the poll limit.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  localparam int REG_AW = 16;
  localparam int WIN_AW = 12;
  localparam int DEV_W  = 5;
  localparam int PAGE_W = 12;

  localparam logic [REG_AW-1:0] CR_CMD  = 16'h80A0;
  localparam logic [REG_AW-1:0] CR_ADDR = 16'h80A1;
  localparam logic [REG_AW-1:0] CR_DATA = 16'h80A2;
  localparam logic [WIN_AW-1:0] WIN_PAGE_SLOT = 12'h800;

  localparam int CMD_GO_BIT = 0;
  localparam int CMD_WR_BIT = 1;

  typedef enum logic [1:0] {RAW_IDLE, RAW_PAGE, RAW_WORD} raw_state_t;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_PWAIT, S_SETA, S_SETD, S_KICK, S_FETCH, S_RESP
  } seq_state_t;

  function automatic logic [PAGE_W-1:0] page_word(input logic [DEV_W-1:0] dev,
                                                  input logic [REG_AW-1:0] a);
    return {dev, a[15:9]};
  endfunction

  function automatic logic [WIN_AW-1:0] word_offset(input logic [REG_AW-1:0] a);
    return {1'b0, a[8:0], 2'b00};
  endfunction

endpackage

// File: rtl/phy_cr_raw_port.sv
module phy_cr_raw_port
  import phy_cr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr,
  input  logic [DEV_W-1:0]  dev,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic              page_done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_stb,
  output logic              bus_we,
  output logic [WIN_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  localparam int PAD_W = DATA_W - PAGE_W;

  raw_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RAW_IDLE;
    end else begin
      case (st)
        RAW_IDLE: if (go) st <= RAW_PAGE;
        RAW_PAGE: if (bus_ack) st <= RAW_WORD;
        RAW_WORD: if (bus_ack) st <= RAW_IDLE;
        default:  st <= RAW_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_stb   = (st != RAW_IDLE);
    bus_we    = (st == RAW_PAGE) ? 1'b1 : wr;
    bus_addr  = (st == RAW_PAGE) ? WIN_PAGE_SLOT : word_offset(reg_addr);
    bus_wdata = (st == RAW_PAGE) ? {{PAD_W{1'b0}}, page_word(dev, reg_addr)} : wdata;
  end

  assign page_done = (st == RAW_PAGE) && bus_ack;
  assign done      = (st == RAW_WORD) && bus_ack;
  assign rdata     = bus_rdata;

endmodule

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
  parameter int POLL_GAP  = 625,
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wait_go,
  output logic gap_done,
  output logic last_try
);

  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int TW = $clog2(MAX_POLLS + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(POLL_GAP - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_POLLS - 1);

  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tries;
  logic          waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      tries   <= '0;
      waiting <= 1'b0;
    end else begin
      if (clr) begin
        tries <= '0;
      end else if (wait_go) begin
        tries <= tries + 1'b1;
      end
      if (wait_go) begin
        waiting <= 1'b1;
        gap_cnt <= GAP_LOAD;
      end else if (waiting) begin
        if (gap_cnt == '0) waiting <= 1'b0;
        else gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  assign gap_done = waiting && (gap_cnt == '0);
  assign last_try = (tries == TRY_LAST);

endmodule

// File: rtl/phy_cr_engine.sv
module phy_cr_engine
  import phy_cr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int POLL_GAP  = 625,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_dev,
  input  logic [15:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_stb,
  output logic              bus_we,
  output logic [11:0]       bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  seq_state_t        state;
  logic              op_wr, post_kick, rsp_err_q;
  logic [DEV_W-1:0]  op_dev;
  logic [REG_AW-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata, rsp_data_q;

  logic              raw_go, raw_wr, raw_done, page_done;
  logic [REG_AW-1:0] raw_addr;
  logic [DATA_W-1:0] raw_wdata, raw_rdata;
  logic              gap_done, last_try, timer_clr, wait_go;

  // named events used by the checker
  logic accept, busy_seen, give_up;

  assign accept    = (state == S_IDLE) && req_valid;
  assign busy_seen = (state == S_POLL) && raw_done && raw_rdata[CMD_GO_BIT];
  assign give_up   = busy_seen && last_try;
  assign wait_go   = busy_seen && !last_try;
  assign timer_clr = accept || ((state == S_KICK) && raw_done && !op_wr);

  always_comb begin
    raw_go    = 1'b1;
    raw_wr    = 1'b0;
    raw_addr  = CR_CMD;
    raw_wdata = '0;
    case (state)
      S_POLL:  raw_addr = CR_CMD;
      S_SETA:  begin raw_wr = 1'b1; raw_addr = CR_ADDR; raw_wdata = DATA_W'(op_addr); end
      S_SETD:  begin raw_wr = 1'b1; raw_addr = CR_DATA; raw_wdata = op_wdata; end
      S_KICK:  begin
        raw_wr = 1'b1;
        raw_addr = CR_CMD;
        raw_wdata[CMD_GO_BIT] = 1'b1;
        raw_wdata[CMD_WR_BIT] = op_wr;
      end
      S_FETCH: raw_addr = CR_DATA;
      default: raw_go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_wr      <= 1'b0;
      op_dev     <= '0;
      op_addr    <= '0;
      op_wdata   <= '0;
      post_kick  <= 1'b0;
      rsp_err_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_wr      <= req_write;
          op_dev     <= req_dev;
          op_addr    <= req_addr;
          op_wdata   <= req_wdata;
          post_kick  <= 1'b0;
          rsp_err_q  <= 1'b0;
          rsp_data_q <= '0;
          state      <= S_POLL;
        end
        S_POLL: if (raw_done) begin
          if (!raw_rdata[CMD_GO_BIT]) state <= post_kick ? S_FETCH : S_SETA;
          else if (last_try) begin
            rsp_err_q <= 1'b1;
            state     <= S_RESP;
          end else state <= S_PWAIT;
        end
        S_PWAIT: if (gap_done) state <= S_POLL;
        S_SETA:  if (raw_done) state <= op_wr ? S_SETD : S_KICK;
        S_SETD:  if (raw_done) state <= S_KICK;
        S_KICK:  if (raw_done) begin
          if (op_wr) state <= S_RESP;
          else begin
            post_kick <= 1'b1;
            state     <= S_POLL;
          end
        end
        S_FETCH: if (raw_done) begin
          rsp_data_q <= raw_rdata;
          state      <= S_RESP;
        end
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_data_q;

  phy_cr_raw_port #(.DATA_W(DATA_W)) u_raw (
    .clk(clk), .rst_n(rst_n), .go(raw_go), .wr(raw_wr), .dev(op_dev),
    .reg_addr(raw_addr), .wdata(raw_wdata), .done(raw_done), .page_done(page_done),
    .rdata(raw_rdata), .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  phy_cr_poll_timer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .wait_go(wait_go),
    .gap_done(gap_done), .last_try(last_try)
  );

endmodule

// File: rtl/phy_cr_engine_chk.sv
module phy_cr_engine_chk #(
  parameter int DATA_W   = 16,
  parameter int POLL_GAP = 625
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [4:0]        req_dev,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_stb,
  input logic              bus_we,
  input logic [11:0]       bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              page_done,
  input logic              busy_seen,
  input logic              give_up
);

  logic [4:0]  dev_q;
  logic        armed;
  logic [31:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      armed <= 1'b0;
      quiet <= '0;
    end else begin
      if (req_valid && req_ready) dev_q <= req_dev;
      if (busy_seen && !give_up) begin
        armed <= 1'b1;
        quiet <= '0;
      end else if (armed) begin
        if (bus_stb) armed <= 1'b0;
        else if (quiet < 32'(POLL_GAP)) quiet <= quiet + 1;
      end
    end
  end

  p_page_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && (bus_addr == 12'h800) |-> bus_we);

  p_word_after_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> bus_stb && (bus_addr != 12'h800));

  p_page_dev_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && (bus_addr == 12'h800) |-> bus_wdata[11:7] == dev_q);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && !bus_ack |=> bus_stb && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_stb);

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  p_poll_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && bus_stb |-> quiet >= 32'(POLL_GAP));

  p_give_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> rsp_valid && rsp_err);

  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);

endmodule

bind phy_cr_engine phy_cr_engine_chk #(.DATA_W(DATA_W), .POLL_GAP(POLL_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_dev(req_dev), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .page_done(page_done), .busy_seen(busy_seen), .give_up(give_up)
);

// File: tb/sim_phy_cr_engine.sv
`timescale 1ns/1ps
module sim_phy_cr_engine;

  localparam int DW = 16;
  localparam int GAP = 4;
  localparam int LIM = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]    req_dev = '0;
  logic [15:0]   req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          bus_stb, bus_we;
  logic [11:0]   bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ack = 1'b0;

  int checks = 0, failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_cr_engine #(.DATA_W(DW), .POLL_GAP(GAP), .MAX_POLLS(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // behavioural transceiver behind the paged window
  logic [11:0] pg_reg = '0;
  logic [15:0] areg = '0, dreg = '0;
  int          busy_left = 0, busy_after = 0;
  bit          busy_forever = 0;
  logic [15:0] phy_mem [int];
  logic [28:0] lg [0:63];
  int          lg_t [0:63];
  int          lg_n = 0;

  function automatic logic [15:0] dflt(input int k);
    return 16'((k * 7 + 3) % 65536);
  endfunction

  always @(posedge clk) begin
    if (bus_stb && !bus_ack) begin
      bus_ack <= 1'b1;
      if (lg_n < 64) begin
        lg[lg_n]   = {bus_we, bus_addr, bus_we ? bus_wdata : 16'h0};
        lg_t[lg_n] = cyc;
        lg_n = lg_n + 1;
      end
      if (bus_addr == 12'h800) begin
        if (bus_we) pg_reg = bus_wdata[11:0];
      end else begin
        int full, dev, key;
        full = (pg_reg % 128) * 512 + (bus_addr / 4) % 512;
        dev  = pg_reg / 128;
        if (full == 32'h80A0) begin
          if (bus_we) begin
            if (bus_wdata % 2 == 1) begin
              key = dev * 65536 + areg;
              if ((bus_wdata / 2) % 2 == 1) phy_mem[key] = dreg;
              else dreg = phy_mem.exists(key) ? phy_mem[key] : dflt(key);
              busy_left = busy_after;
            end
          end else begin
            bus_rdata <= (busy_forever || busy_left > 0) ? 16'h1 : 16'h0;
            if (busy_left > 0) busy_left = busy_left - 1;
          end
        end else if (full == 32'h80A1) begin
          if (bus_we) areg = bus_wdata;
        end else if (full == 32'h80A2) begin
          if (bus_we) dreg = bus_wdata;
          else bus_rdata <= dreg;
        end else if (!bus_we) bus_rdata <= 16'h0;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected bus log
  logic [28:0] ex [0:63];
  int          ex_n;
  logic [15:0] shadow [int];

  task automatic add(input bit we, input int a, input int d);
    ex[ex_n] = {we, 12'(a), we ? 16'(d) : 16'h0};
    ex_n++;
  endtask

  task automatic access(input int pw, input bit we, input int reg_a, input int d);
    add(1'b1, 2048, pw);
    add(we, (reg_a % 512) * 4, d);
  endtask

  task automatic run_op(input bit wr, input int dev, input int a, input int d,
                        input int pre, input int post, input bit hang, input string rq);
    int pw, key, n, waited;
    logic [15:0] exp_rd;
    bit got_err;
    logic [15:0] got_rd;
    pw = dev * 128 + (32'h80A0 / 512) % 128;
    key = dev * 65536 + a;
    ex_n = 0;
    n = hang ? LIM : pre + 1;
    for (int i = 0; i < n; i++) access(pw, 1'b0, 32'h80A0, 0);
    if (!hang) begin
      access(pw, 1'b1, 32'h80A1, a);
      if (wr) begin
        access(pw, 1'b1, 32'h80A2, d);
        access(pw, 1'b1, 32'h80A0, 3);
      end else begin
        access(pw, 1'b1, 32'h80A0, 1);
        for (int i = 0; i <= post; i++) access(pw, 1'b0, 32'h80A0, 0);
        access(pw, 1'b0, 32'h80A2, 0);
      end
    end
    if (hang || wr) exp_rd = 16'h0;
    else exp_rd = shadow.exists(key) ? shadow[key] : dflt(key);
    if (wr && !hang) shadow[key] = 16'(d);

    @(negedge clk);
    waited = 0;
    while (!req_ready && waited < 1000) begin @(negedge clk); waited++; end
    busy_left = pre; busy_after = post; busy_forever = hang;
    lg_n = 0;
    req_valid = 1'b1; req_write = wr; req_dev = 5'(dev);
    req_addr = 16'(a); req_wdata = 16'(d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8", "ready low after accept", 32'(req_ready), 0);
    waited = 0;
    while (!rsp_valid && waited < 2000) begin @(negedge clk); waited++; end
    got_err = rsp_err; got_rd = rsp_rdata;
    chk(rsp_valid == 1'b1, rq, "response seen", 32'(rsp_valid), 1);
    chk(got_err == hang, hang ? "R7" : rq, "rsp_err", 32'(got_err), 32'(hang));
    chk(got_rd == exp_rd, hang ? "R7" : "R4", "rsp_rdata", 32'(got_rd), 32'(exp_rd));
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8", "pulse end / ready back",
        {30'h0, rsp_valid, req_ready}, 32'h1);
    // bus trace: page word, offsets, sequence and length
    chk(lg_n == ex_n, rq, "bus access count", 32'(lg_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < lg_n; i++)
      if (lg[i] != ex[i]) begin
        chk(1'b0, (i % 2 == 0) ? "R1" : "R2", $sformatf("access %0d", i),
            32'(lg[i]), 32'(ex[i]));
        break;
      end
    // spacing between consecutive status polls
    for (int i = 3; i < lg_n; i += 2)
      if (lg[i] == 29'h0_0280_0000 >> 0 && lg[i][28] == 1'b0 && lg[i-2] == lg[i]
          && lg[i][27:16] == 12'h280)
        chk(lg_t[i] - lg_t[i-2] > GAP, "R6", "poll spacing",
            32'(lg_t[i] - lg_t[i-2]), GAP + 1);
  endtask

  int devs [3] = '{0, 5, 31};
  int adrs [5] = '{32'h0000, 32'h01FF, 32'h0200, 32'hFFFF, 32'h1234};

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && bus_stb == 1'b0 && rsp_valid == 1'b0, "R8", "reset state",
        {29'h0, req_ready, bus_stb, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    // unwritten register reads give the model's default contents
    run_op(1'b0, 9, 32'h0BEE, 0, 0, 0, 1'b0, "R4");
    run_op(1'b0, 9, 32'h0BEE, 0, 2, 2, 1'b0, "R4");
    for (int di = 0; di < 3; di++)
      for (int ai = 0; ai < 5; ai++)
        for (int k = 0; k < LIM; k++) begin
          run_op(1'b1, devs[di], adrs[ai], (di * 4099 + ai * 257 + k * 31 + 17) % 65536,
                 k, 0, 1'b0, "R5");
          run_op(1'b0, devs[di], adrs[ai], 0, (k + 1) % LIM, k, 1'b0, "R4");
        end
    // the same address on another device keeps its own value (R9)
    run_op(1'b1, 3, 32'h0042, 32'hA5A5, 0, 0, 1'b0, "R9");
    run_op(1'b1, 4, 32'h0042, 32'h5A5A, 0, 0, 1'b0, "R9");
    run_op(1'b0, 3, 32'h0042, 0, 0, 1, 1'b0, "R9");
    // poll limit reached before command and in a write
    run_op(1'b0, 2, 32'h0077, 0, 0, 0, 1'b1, "R7");
    run_op(1'b1, 2, 32'h0077, 32'h1111, 0, 0, 1'b1, "R7");
    // after a timeout, normal operation resumes
    run_op(1'b0, 2, 32'h0077, 0, 1, 0, 1'b0, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule